// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. A request carries the virtual address, whether the access is a store, the page table root pointer and a large-page enable. The walker fetches the directory entry. When that entry names a 4 MB page, the walk ends there. Otherwise it fetches the table entry that maps a 4 KB page. It reports the physical address (40 bits, so a large page can reach above 4 GB), the page size, and the combined user and write permissions. If the walk cannot complete, it reports a fault and its cause instead.

The walker keeps the accessed and dirty flags of the entries up to date. It does this through a conditional write (compare-and-set) on a memory port with a single outstanding request. If a directory flag update loses the compare, only that entry is fetched again. If the final entry's update loses the compare, the whole walk starts over. Protection decisions and the formatting of a fault code are left to the blocks that consume the result.

The controller is a state machine with these states. ST_IDLE accepts a request and moves to ST_DIR_RD. ST_DIR_RD issues the directory read and, once it is accepted, moves to ST_DIR_WAIT. On the data, ST_DIR_WAIT goes to one of four places: ST_FAULT, ST_LEAF_CHK for a large page, ST_DIR_CAS when the accessed flag is clear, or ST_TBL_RD. ST_DIR_CAS moves to ST_DIR_CAS_WAIT. That state goes to ST_TBL_RD on success or back to ST_DIR_RD on a mismatch. ST_TBL_RD moves to ST_TBL_WAIT, which goes to ST_FAULT or ST_LEAF_CHK. ST_LEAF_CHK goes to ST_LEAF_CAS when flags must be set, and to ST_DONE otherwise. ST_LEAF_CAS moves to ST_LEAF_CAS_WAIT, which goes to ST_DONE on success or to ST_DIR_RD on a mismatch. ST_DONE and ST_FAULT each last one cycle and return to ST_IDLE.

Top module: `ptw2l_walker`

## Requirements
- R1: The first read of a walk targets {root_base[31:12], va[31:22], 2'b00} and is issued in the cycle after the request is accepted.
- R2: A walk that descends reads the table entry at {directory entry[31:12], va[21:12], 2'b00}.
- R3: An entry whose bit 0 (present) is clear, at either level, ends the walk with fault high and fault_cause = 1, and issues no conditional write.
- R4: A directory entry with bit 7 (size) set, while large_en is high, maps a 4 MB page: the walk reads no table entry and reports page_large = 1. With large_en low, the same entry is treated as a pointer to a table.
- R5: For a 4 MB page, phys_addr = {entry[20:13], entry[31:22], va[21:0]}.
- R6: On a 4 MB page, a set entry bit 21 ends the walk with fault_cause = 2 and issues no conditional write.
- R7: A directory entry that points to a table and has bit 5 (accessed) clear is updated before the walk descends. The conditional write expects the value read and writes that value with bit 5 set. On a mismatch, only the directory entry is read again.
- R8: The final entry is updated so that it has bit 5 set, and also bit 6 (dirty) set on a store. The update is skipped when those bits are already set.
- R9: A mismatch on the final entry's conditional write restarts the walk from the directory read.
- R10: On a non-store access to a page whose final entry had bit 6 clear, perm_write is 0.
- R11: perm_user is the AND of bit 2 of the directory and final entries. perm_write is the AND of their bit 1, subject to R10.
- R12: For a 4 KB page, phys_addr = {8'h00, entry[31:12], va[11:0]}.
- R13: Only one memory request is outstanding at a time. A read or conditional-write request holds its address and data until it is accepted. busy is high from the cycle after acceptance through the single cycle in which done or fault is high, and req_ready is high only while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address |
| req_store | input | 1 | Access is a store |
| root_base | input | 32 | Page table root pointer, low 12 bits ignored |
| large_en | input | 1 | Enables 4 MB pages |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse, translation valid |
| fault | output | 1 | One-cycle pulse, walk failed |
| fault_cause | output | 2 | 1 not present, 2 reserved bit |
| phys_addr | output | 40 | Translated physical address |
| page_large | output | 1 | Result is a 4 MB page |
| perm_user | output | 1 | Combined user permission |
| perm_write | output | 1 | Combined write permission |
| mem_rd_valid | output | 1 | Read request |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_resp_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| mem_cas_valid | output | 1 | Conditional write request |
| mem_cas_ready | input | 1 | Conditional write accepted |
| mem_cas_addr | output | 32 | Conditional write byte address |
| mem_cas_expect | output | 32 | Value memory must hold |
| mem_cas_value | output | 32 | Value written on a match |
| mem_cas_resp_valid | input | 1 | Conditional write finished |
| mem_cas_ok | input | 1 | Compare matched, value written |

## Verification
busy is due in the cycle after a request is accepted and stays high through the done or fault cycle. The bench models this per clock and compares it on every falling edge. The translation result has no fixed latency, because it depends on memory stalls, retries and restarts. The bench therefore waits for the done or fault pulse, samples every result port in that cycle, and compares it with a behavioural model. That model also predicts how many reads and conditional writes the walk must issue and what the page table memory holds at the end. Stalled ready patterns and injected compare failures exercise the paths in which the result arrives later.

// File: rtl/ptw2l_pkg.sv
package ptw2l_pkg;

    localparam int VA_W        = 32;
    localparam int ENT_W       = 32;
    localparam int PA_W        = 40;
    localparam int IDX_W       = 10;
    localparam int SMALL_OFF_W = 12;
    localparam int LARGE_OFF_W = SMALL_OFF_W + IDX_W;
    localparam int HI_W        = PA_W - ENT_W;
    localparam int FRAME_W     = ENT_W - SMALL_OFF_W;

    localparam int B_PRESENT   = 0;
    localparam int B_WRITE     = 1;
    localparam int B_USER      = 2;
    localparam int B_ACCESSED  = 5;
    localparam int B_DIRTY     = 6;
    localparam int B_SIZE      = 7;
    localparam int B_HI_LSB    = 13;
    localparam int B_LARGE_RSV = B_HI_LSB + HI_W;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WAIT,
        ST_DIR_CAS,
        ST_DIR_CAS_WAIT,
        ST_TBL_RD,
        ST_TBL_WAIT,
        ST_LEAF_CHK,
        ST_LEAF_CAS,
        ST_LEAF_CAS_WAIT,
        ST_DONE,
        ST_FAULT
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE        = 2'd0,
        CAUSE_NOT_PRESENT = 2'd1,
        CAUSE_RESERVED    = 2'd2
    } fault_cause_e;

endpackage

// File: rtl/ptw2l_ptr_gen.sv
module ptw2l_ptr_gen
    import ptw2l_pkg::*;
#(
    parameter int AW = ENT_W,
    parameter int IW = IDX_W,
    parameter int OW = SMALL_OFF_W
) (
    input  logic [AW-OW-1:0] root_frame,
    input  logic [AW-OW-1:0] dir_frame,
    input  logic [IW-1:0]    dir_idx,
    input  logic [IW-1:0]    tbl_idx,
    output logic [AW-1:0]    dir_ptr,
    output logic [AW-1:0]    tbl_ptr
);
    // Entries are 4 bytes wide, so the index is shifted by the slot width.
    localparam int SLOT_W = OW - IW;

    assign dir_ptr = {root_frame, dir_idx, {SLOT_W{1'b0}}};
    assign tbl_ptr = {dir_frame,  tbl_idx, {SLOT_W{1'b0}}};
endmodule

// File: rtl/ptw2l_leaf_eval.sv
module ptw2l_leaf_eval
    import ptw2l_pkg::*;
(
    input  logic                   dir_user,
    input  logic                   dir_write,
    input  logic [ENT_W-1:0]       leaf_entry,
    input  logic                   is_large,
    input  logic                   is_store,
    input  logic [LARGE_OFF_W-1:0] va_off,
    output logic [ENT_W-1:0]       set_bits,
    output logic                   need_update,
    output logic [PA_W-1:0]        phys_addr,
    output logic                   user_ok,
    output logic                   write_ok
);
    always_comb begin
        set_bits             = '0;
        set_bits[B_ACCESSED] = 1'b1;
        set_bits[B_DIRTY]    = is_store;
    end

    assign need_update = |(set_bits & ~leaf_entry);

    // For a large page the leaf is the directory entry itself, so the AND
    // of the two copies reduces to the entry's own permission bits.
    assign user_ok  = dir_user & leaf_entry[B_USER];
    assign write_ok = dir_write & leaf_entry[B_WRITE] &
                      (is_store | leaf_entry[B_DIRTY]);

    always_comb begin
        if (is_large) begin
            phys_addr = {leaf_entry[B_LARGE_RSV-1:B_HI_LSB],
                         leaf_entry[ENT_W-1:LARGE_OFF_W],
                         va_off};
        end else begin
            phys_addr = {{HI_W{1'b0}},
                         leaf_entry[ENT_W-1:SMALL_OFF_W],
                         va_off[SMALL_OFF_W-1:0]};
        end
    end
endmodule

// File: rtl/ptw2l_walker.sv
module ptw2l_walker
    import ptw2l_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_store,
    input  logic [ENT_W-1:0] root_base,
    input  logic             large_en,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic [1:0]       fault_cause,
    output logic [PA_W-1:0]  phys_addr,
    output logic             page_large,
    output logic             perm_user,
    output logic             perm_write,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [ENT_W-1:0] mem_rd_addr,
    input  logic             mem_rd_resp_valid,
    input  logic [ENT_W-1:0] mem_rd_data,
    output logic             mem_cas_valid,
    input  logic             mem_cas_ready,
    output logic [ENT_W-1:0] mem_cas_addr,
    output logic [ENT_W-1:0] mem_cas_expect,
    output logic [ENT_W-1:0] mem_cas_value,
    input  logic             mem_cas_resp_valid,
    input  logic             mem_cas_ok
);
    localparam logic [ENT_W-1:0] ACC_ONLY = {{(ENT_W-1){1'b0}}, 1'b1} << B_ACCESSED;

    walk_state_e st_q, st_d;

    logic [VA_W-1:0]    va_q;
    logic               store_q;
    logic               large_en_q;
    logic [FRAME_W-1:0] root_frame_q;
    logic [ENT_W-1:0]   dir_q;
    logic [ENT_W-1:0]   leaf_q;
    logic [ENT_W-1:0]   leaf_ptr_q;
    logic               leaf_large_q;
    fault_cause_e       cause_q;
    logic [PA_W-1:0]    pa_q;
    logic               user_q;
    logic               write_q;
    logic               large_res_q;

    logic [ENT_W-1:0] dir_ptr;
    logic [ENT_W-1:0] tbl_ptr;
    logic [ENT_W-1:0] set_bits;
    logic             need_update;
    logic [PA_W-1:0]  pa_w;
    logic             user_w;
    logic             write_w;

    logic rd_present;
    logic rd_large;
    logic rd_rsv;
    logic rd_accessed;

    assign rd_present  = mem_rd_data[B_PRESENT];
    assign rd_large    = mem_rd_data[B_SIZE] & large_en_q;
    assign rd_rsv      = mem_rd_data[B_LARGE_RSV];
    assign rd_accessed = mem_rd_data[B_ACCESSED];

    ptw2l_ptr_gen #(
        .AW (ENT_W),
        .IW (IDX_W),
        .OW (SMALL_OFF_W)
    ) u_ptr_gen (
        .root_frame (root_frame_q),
        .dir_frame  (dir_q[ENT_W-1:SMALL_OFF_W]),
        .dir_idx    (va_q[VA_W-1 -: IDX_W]),
        .tbl_idx    (va_q[LARGE_OFF_W-1 -: IDX_W]),
        .dir_ptr    (dir_ptr),
        .tbl_ptr    (tbl_ptr)
    );

    ptw2l_leaf_eval u_leaf_eval (
        .dir_user    (dir_q[B_USER]),
        .dir_write   (dir_q[B_WRITE]),
        .leaf_entry  (leaf_q),
        .is_large    (leaf_large_q),
        .is_store    (store_q),
        .va_off      (va_q[LARGE_OFF_W-1:0]),
        .set_bits    (set_bits),
        .need_update (need_update),
        .phys_addr   (pa_w),
        .user_ok     (user_w),
        .write_ok    (write_w)
    );

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) st_d = ST_DIR_RD;
            end
            ST_DIR_RD: begin
                if (mem_rd_ready) st_d = ST_DIR_WAIT;
            end
            ST_DIR_WAIT: begin
                if (mem_rd_resp_valid) begin
                    if (!rd_present)      st_d = ST_FAULT;
                    else if (rd_large)    st_d = rd_rsv ? ST_FAULT : ST_LEAF_CHK;
                    else if (rd_accessed) st_d = ST_TBL_RD;
                    else                  st_d = ST_DIR_CAS;
                end
            end
            ST_DIR_CAS: begin
                if (mem_cas_ready) st_d = ST_DIR_CAS_WAIT;
            end
            ST_DIR_CAS_WAIT: begin
                if (mem_cas_resp_valid) st_d = mem_cas_ok ? ST_TBL_RD : ST_DIR_RD;
            end
            ST_TBL_RD: begin
                if (mem_rd_ready) st_d = ST_TBL_WAIT;
            end
            ST_TBL_WAIT: begin
                if (mem_rd_resp_valid) st_d = rd_present ? ST_LEAF_CHK : ST_FAULT;
            end
            ST_LEAF_CHK: begin
                st_d = need_update ? ST_LEAF_CAS : ST_DONE;
            end
            ST_LEAF_CAS: begin
                if (mem_cas_ready) st_d = ST_LEAF_CAS_WAIT;
            end
            ST_LEAF_CAS_WAIT: begin
                if (mem_cas_resp_valid) st_d = mem_cas_ok ? ST_DONE : ST_DIR_RD;
            end
            ST_DONE:  st_d = ST_IDLE;
            ST_FAULT: st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Walk context and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q         <= '0;
            store_q      <= 1'b0;
            large_en_q   <= 1'b0;
            root_frame_q <= '0;
            dir_q        <= '0;
            leaf_q       <= '0;
            leaf_ptr_q   <= '0;
            leaf_large_q <= 1'b0;
            cause_q      <= CAUSE_NONE;
            pa_q         <= '0;
            user_q       <= 1'b0;
            write_q      <= 1'b0;
            large_res_q  <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q         <= req_va;
                        store_q      <= req_store;
                        large_en_q   <= large_en;
                        root_frame_q <= root_base[ENT_W-1:SMALL_OFF_W];
                        cause_q      <= CAUSE_NONE;
                    end
                end
                ST_DIR_WAIT: begin
                    if (mem_rd_resp_valid) begin
                        dir_q <= mem_rd_data;
                        if (!rd_present) begin
                            cause_q <= CAUSE_NOT_PRESENT;
                        end else if (rd_large) begin
                            if (rd_rsv) cause_q <= CAUSE_RESERVED;
                            leaf_q       <= mem_rd_data;
                            leaf_ptr_q   <= dir_ptr;
                            leaf_large_q <= 1'b1;
                        end
                    end
                end
                ST_TBL_WAIT: begin
                    if (mem_rd_resp_valid) begin
                        if (!rd_present) begin
                            cause_q <= CAUSE_NOT_PRESENT;
                        end else begin
                            leaf_q       <= mem_rd_data;
                            leaf_ptr_q   <= tbl_ptr;
                            leaf_large_q <= 1'b0;
                        end
                    end
                end
                ST_LEAF_CHK: begin
                    pa_q        <= pa_w;
                    user_q      <= user_w;
                    write_q     <= write_w;
                    large_res_q <= leaf_large_q;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready      = 1'b0;
        busy           = 1'b1;
        done           = 1'b0;
        fault          = 1'b0;
        mem_rd_valid   = 1'b0;
        mem_rd_addr    = dir_ptr;
        mem_cas_valid  = 1'b0;
        mem_cas_addr   = dir_ptr;
        mem_cas_expect = dir_q;
        mem_cas_value  = dir_q | ACC_ONLY;
        unique case (st_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_DIR_RD: begin
                mem_rd_valid = 1'b1;
            end
            ST_TBL_RD: begin
                mem_rd_valid = 1'b1;
                mem_rd_addr  = tbl_ptr;
            end
            ST_DIR_CAS: begin
                mem_cas_valid = 1'b1;
            end
            ST_LEAF_CAS: begin
                mem_cas_valid  = 1'b1;
                mem_cas_addr   = leaf_ptr_q;
                mem_cas_expect = leaf_q;
                mem_cas_value  = leaf_q | set_bits;
            end
            ST_DONE:  done  = 1'b1;
            ST_FAULT: fault = 1'b1;
            default: ;
        endcase
    end

    assign fault_cause = cause_q;
    assign phys_addr   = pa_q;
    assign page_large  = large_res_q;
    assign perm_user   = user_q;
    assign perm_write  = write_q;
endmodule

// File: rtl/ptw2l_walker_chk.sv
module ptw2l_walker_chk
    import ptw2l_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             busy,
    input logic             done,
    input logic             fault,
    input logic [1:0]       fault_cause,
    input logic             mem_rd_valid,
    input logic             mem_rd_ready,
    input logic [ENT_W-1:0] mem_rd_addr,
    input logic             mem_cas_valid,
    input logic             mem_cas_ready,
    input logic [ENT_W-1:0] mem_cas_addr,
    input logic [ENT_W-1:0] mem_cas_expect,
    input logic [ENT_W-1:0] mem_cas_value
);
    assert_single_request_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_valid && mem_cas_valid));

    assert_read_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

    assert_cas_held_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cas_valid && !mem_cas_ready) |=> (mem_cas_valid && $stable(mem_cas_addr)
            && $stable(mem_cas_expect) && $stable(mem_cas_value)));

    // R7 and R8: an update only ever adds flag bits to the expected value.
    assert_cas_sets_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cas_valid |-> (((mem_cas_expect & ~mem_cas_value) == '0)
            && ((mem_cas_value & ~mem_cas_expect) != '0)));

    assert_first_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_rd_valid && busy));

    assert_end_releases_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |=> (!busy && req_ready && !done && !fault));

    assert_fault_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_cause == CAUSE_NOT_PRESENT || fault_cause == CAUSE_RESERVED));

    assert_end_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
endmodule

bind ptw2l_walker ptw2l_walker_chk u_chk (.*);

// File: tb/ptw2l_walker_tb.sv
`timescale 1ns/1ps
module ptw2l_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        req_store = 1'b0;
    logic [31:0] root_base = '0;
    logic        large_en = 1'b0;
    logic        busy, done, fault;
    logic [1:0]  fault_cause;
    logic [39:0] phys_addr;
    logic        page_large, perm_user, perm_write;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b1;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_resp_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_cas_valid;
    logic        mem_cas_ready = 1'b1;
    logic [31:0] mem_cas_addr, mem_cas_expect, mem_cas_value;
    logic        mem_cas_resp_valid = 1'b0;
    logic        mem_cas_ok = 1'b0;

    always #2 clk = ~clk;

    ptw2l_walker u_dut (.*);

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mem     [logic [31:0]];
    logic [31:0] ref_mem [logic [31:0]];
    bit          stall = 0;
    bit          inj_pending = 0;
    logic [31:0] inj_addr = '0;
    int          rd_cnt = 0;
    int          cas_cnt = 0;
    logic [31:0] first_rd = '0;
    logic        exp_busy = 1'b0;

    bit          ref_inj;
    logic [31:0] ref_inj_addr;
    bit          exp_fault;
    logic [1:0]  exp_cause;
    logic [39:0] exp_pa;
    bit          exp_user, exp_write, exp_large;
    int          exp_reads, exp_cas;
    logic [31:0] exp_first, exp_dir_addr, exp_leaf_addr;

    function automatic logic [31:0] mrd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction
    function automatic logic [31:0] rrd(input logic [31:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
    endfunction

    task automatic put(input logic [31:0] a, input logic [31:0] v);
        mem[a] = v;
        ref_mem[a] = v;
    endtask

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Page table memory with one-cycle responses and optional injected interference
    always @(posedge clk) begin
        logic [31:0] cur;
        mem_rd_resp_valid  <= 1'b0;
        mem_cas_resp_valid <= 1'b0;
        if (mem_rd_valid && mem_rd_ready) begin
            rd_cnt++;
            if (rd_cnt == 1) first_rd = mem_rd_addr;
            mem_rd_resp_valid <= 1'b1;
            mem_rd_data       <= mrd(mem_rd_addr);
        end
        if (mem_cas_valid && mem_cas_ready) begin
            cas_cnt++;
            cur = mrd(mem_cas_addr);
            if (inj_pending && mem_cas_addr == inj_addr) begin
                cur = cur ^ 32'h200;
                inj_pending = 0;
            end
            if (cur == mem_cas_expect) begin
                mem[mem_cas_addr] = mem_cas_value;
                mem_cas_ok <= 1'b1;
            end else begin
                mem[mem_cas_addr] = cur;
                mem_cas_ok <= 1'b0;
            end
            mem_cas_resp_valid <= 1'b1;
        end
        if (stall) begin
            mem_rd_ready  <= ~mem_rd_ready;
            mem_cas_ready <= ~mem_cas_ready;
        end else begin
            mem_rd_ready  <= 1'b1;
            mem_cas_ready <= 1'b1;
        end
    end

    // Per-cycle model of busy and req_ready (R13)
    always @(posedge clk) begin
        if (!rst_n)                      exp_busy <= 1'b0;
        else if (req_valid && req_ready) exp_busy <= 1'b1;
        else if (done || fault)          exp_busy <= 1'b0;
    end
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R13 busy per cycle", {63'd0, busy}, {63'd0, exp_busy});
            chk("R13 req_ready per cycle", {63'd0, req_ready}, {63'd0, !exp_busy});
        end
    end

    // Behavioural reference walk on the reference memory
    task automatic ref_walk(input logic [31:0] va, input logic st,
                            input logic [31:0] root, input logic pse);
        logic [31:0] d, t, leaf, daddr, taddr, laddr, setm;
        bit finished, dir_ok, lg;
        exp_reads = 0; exp_cas = 0; exp_fault = 0; exp_cause = 0;
        exp_pa = '0; exp_user = 0; exp_write = 0; exp_large = 0;
        daddr = {root[31:12], va[31:22], 2'b00};
        exp_first = daddr; exp_dir_addr = daddr; exp_leaf_addr = daddr;
        finished = 0;
        while (!finished) begin
            dir_ok = 0; d = '0;
            while (!dir_ok) begin
                exp_reads++;
                d = rrd(daddr);
                if (!d[0]) begin exp_fault = 1; exp_cause = 2'd1; return; end
                if ((d[7] && pse) || d[5]) dir_ok = 1;
                else begin
                    exp_cas++;
                    if (ref_inj && ref_inj_addr == daddr) begin
                        ref_mem[daddr] = d ^ 32'h200;
                        ref_inj = 0;
                    end else begin
                        ref_mem[daddr] = d | 32'h20;
                        dir_ok = 1;
                    end
                end
            end
            if (d[7] && pse) begin
                if (d[21]) begin exp_fault = 1; exp_cause = 2'd2; return; end
                lg = 1; leaf = d; laddr = daddr;
            end else begin
                lg = 0;
                taddr = {d[31:12], va[21:12], 2'b00};
                exp_leaf_addr = taddr;
                exp_reads++;
                t = rrd(taddr);
                if (!t[0]) begin exp_fault = 1; exp_cause = 2'd1; return; end
                leaf = t; laddr = taddr;
            end
            setm = 32'h20 | (st ? 32'h40 : 32'h0);
            if ((setm & ~leaf) != 0) begin
                exp_cas++;
                if (ref_inj && ref_inj_addr == laddr) begin
                    ref_mem[laddr] = leaf ^ 32'h200;
                    ref_inj = 0;
                    continue;
                end
                ref_mem[laddr] = leaf | setm;
            end
            exp_large = lg;
            exp_user  = d[2] & leaf[2];
            exp_write = d[1] & leaf[1] & (st | leaf[6]);
            exp_pa    = lg ? {leaf[20:13], leaf[31:22], va[21:0]}
                           : {8'h00, leaf[31:12], va[11:0]};
            finished = 1;
        end
    endtask

    task automatic run_case(input string tag, input logic [31:0] va, input logic st,
                            input logic [31:0] root, input logic pse,
                            input bit inject, input logic [31:0] iaddr);
        int cyc;
        ref_inj = inject; ref_inj_addr = iaddr;
        ref_walk(va, st, root, pse);
        @(negedge clk);
        inj_pending = inject; inj_addr = iaddr;
        rd_cnt = 0; cas_cnt = 0; first_rd = '0;
        req_va = va; req_store = st; root_base = root; large_en = pse;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!(done || fault) && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        $display("case %s", tag);
        chk("R3 R6 fault flag", {63'd0, fault}, {63'd0, exp_fault});
        chk("R13 done flag", {63'd0, done}, {63'd0, !exp_fault});
        if (exp_fault) begin
            chk(exp_cause == 2'd2 ? "R6 fault cause" : "R3 fault cause",
                {62'd0, fault_cause}, {62'd0, exp_cause});
        end else begin
            chk(exp_large ? "R5 large physical address" : "R12 small physical address",
                {24'd0, phys_addr}, {24'd0, exp_pa});
            chk("R4 page size", {63'd0, page_large}, {63'd0, exp_large});
            chk("R11 user permission", {63'd0, perm_user}, {63'd0, exp_user});
            chk("R10 R11 write permission", {63'd0, perm_write}, {63'd0, exp_write});
        end
        chk("R1 first read address", {32'd0, first_rd}, {32'd0, exp_first});
        chk("R2 R4 R9 read count", 64'(rd_cnt), 64'(exp_reads));
        chk("R3 R7 R8 R9 conditional write count", 64'(cas_cnt), 64'(exp_cas));
        chk("R7 directory entry in memory", {32'd0, mrd(exp_dir_addr)}, {32'd0, rrd(exp_dir_addr)});
        chk("R8 final entry in memory", {32'd0, mrd(exp_leaf_addr)}, {32'd0, rrd(exp_leaf_addr)});
    endtask

    localparam logic [31:0] ROOT = 32'h0001_0ABC;

    initial begin
        repeat (3) @(negedge clk);
        chk("R13 reset busy", {63'd0, busy}, 64'd0);
        chk("R13 reset done", {63'd0, done}, 64'd0);
        chk("R13 reset fault", {63'd0, fault}, 64'd0);
        chk("R13 reset read request", {63'd0, mem_rd_valid}, 64'd0);
        chk("R13 reset write request", {63'd0, mem_cas_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13 idle req_ready", {63'd0, req_ready}, 64'd1);

        // Small page tables
        put(32'h0001_0004, 32'h0002_0007);
        put(32'h0002_000C, 32'h1234_5007);
        put(32'h0001_000C, 32'h0003_0027);
        put(32'h0003_0000, 32'h0000_0006);
        put(32'h0001_0014, 32'h0020_0087);
        put(32'h0001_0010, 32'hF00B_40C7);
        put(32'hF00B_4AAC, 32'h0777_7005);
        put(32'h0001_0018, 32'h0004_0003);
        put(32'h0004_0014, 32'h0055_5067);
        put(32'h0001_001C, 32'h0005_0027);
        put(32'h0005_001C, 32'h0066_6005);
        put(32'h0001_0020, 32'h0008_0007);
        put(32'h0008_0000, 32'hFFFF_F007);

        run_case("R2 R7 R8 R10 R12 load, flags clear", 32'h0040_3123, 1'b0, ROOT, 1'b1, 0, '0);
        run_case("R8 store sets dirty", 32'h0040_3123, 1'b1, ROOT, 1'b1, 0, '0);
        run_case("R8 R10 load, flags already set", 32'h0040_3123, 1'b0, ROOT, 1'b1, 0, '0);
        run_case("R3 directory not present", 32'h0080_0000, 1'b0, ROOT, 1'b1, 0, '0);
        run_case("R3 table not present", 32'h00C0_0000, 1'b1, ROOT, 1'b1, 0, '0);
        run_case("R4 R5 large page", 32'h012A_BCDE, 1'b0, ROOT, 1'b1, 0, '0);
        run_case("R6 large page reserved bit", 32'h0140_0000, 1'b0, ROOT, 1'b1, 0, '0);
        run_case("R4 size bit with large pages off", 32'h012A_BCDE, 1'b0, ROOT, 1'b0, 0, '0);
        run_case("R7 R11 directory update mismatch", 32'h0180_5010, 1'b0, ROOT, 1'b1, 1, 32'h0001_0018);
        run_case("R9 final update mismatch", 32'h01C0_7001, 1'b1, ROOT, 1'b1, 1, 32'h0005_001C);
        stall = 1;
        run_case("R13 stalled port store", 32'h0200_0FFF, 1'b1, ROOT, 1'b1, 0, '0);
        stall = 0;
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R13 watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule